// File: doc/BRIEF.md
# Binary-Field Multiplicative Inverter (Fermat / Itoh–Tsujii)

This block computes the multiplicative inverse of a nonzero element of GF(2^163). It raises the operand to the power 2^m − 2, where m = 163. The exponent is built with an addition chain that is driven by the binary digits of m − 1. The datapath has two parts: a combinational modular squarer that finishes in one clock, and a bit-serial multiplier that takes m clocks. A small sequencer decides how many squarings precede each multiplication.

At every point in the chain the accumulator holds a^(2^k − 1) for the current run length k. The sequencer walks the bits of m − 1 below the most significant one, from high to low. Each bit begins with a doubling step: the accumulator is squared k times, and the result is multiplied by a copy of the accumulator saved before those squarings, which gives k ← 2k. When the bit is 1, one more squaring and a multiplication by the original operand follow, which gives k ← k + 1. When the walk ends, k = m − 1. One last squaring then yields a^(2^m − 2) = a^-1.

A host places the operand on `din` and pulses `start`. The result appears on `dout` in the cycle that `done` pulses, and it stays there until the next accepted start.

Top module: `gf2m_fermat_inv`

## Requirements
- R1: While reset is held and after its release, `busy` and `done` are 0 and `dout` is all zeros.
- R2: For every nonzero input a, the product of a and `dout` (field multiplication modulo z^163 + z^7 + z^6 + z^3 + 1) equals 1 when `done` pulses.
- R3: An input of 1 returns exactly 1. An input of z (bit 1 set, all other bits clear) returns z^162 + z^6 + z^5 + z^2.
- R4: After the clock edge that samples `start`, `busy` stays high for exactly (m − 2) + 9·m + 1 = 1629 cycles. That is 161 squarings for the chain, nine m-cycle multiplications and the closing squaring.
- R5: `done` is high for exactly one cycle. It rises in the same cycle that `busy` falls.
- R6: A `start` pulse while `busy` is high is ignored. The running computation finishes on schedule with the result for the original operand.
- R7: While the block is idle and `start` is low, `dout` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins an inversion of `din` when the block is idle |
| din | input | 163 | Field element to invert, polynomial basis, bit i = coefficient of z^i |
| dout | output | 163 | Inverse, valid from the `done` cycle onward |
| busy | output | 1 | High while an inversion is in progress |
| done | output | 1 | One-cycle pulse when `dout` holds the new inverse |

## Verification
The properties assume that `start` is a single-cycle pulse and that `din` is nonzero whenever a start is accepted. Zero has no inverse, and for zero the chain simply returns zero. The stimulus feeds only nonzero field elements, and it drives `start` for exactly one clock on the falling edge. The only exception is the deliberate start pulse during a busy run. That pulse checks that the block ignores it: the timing and the result must stay those of the first operand.

// File: rtl/gf2m_fermat_inv.sv
module gf2m_fermat_inv #(
  parameter int M = 163,
  parameter logic [M-1:0] PLOW = {{(M-8){1'b0}}, 8'hC9}
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [M-1:0] din,
  output logic [M-1:0] dout,
  output logic         busy,
  output logic         done
);
  localparam int EW = $clog2(M);
  localparam int IW = $clog2(EW) + 1;
  localparam int CW = $clog2(M);
  localparam logic [EW-1:0] EXP = EW'(M - 1);

  typedef enum logic [1:0] {S_IDLE, S_SQ, S_MUL, S_FIN} st_t;
  st_t st;

  logic [M-1:0]  ar, b, t, acc, nacc, opnd;
  logic [EW-1:0] k, cnt, knext;
  logic [IW-1:0] idx;
  logic [CW-1:0] mc;
  logic          inc;

  function automatic logic [M-1:0] sq(input logic [M-1:0] x);
    logic [2*M-2:0] v;
    v = '0;
    for (int i = 0; i < M; i++) v[2*i] = x[i];
    for (int i = 2*M-2; i >= M; i--)
      if (v[i]) begin
        v[i] = 1'b0;
        v[i-M +: M] = v[i-M +: M] ^ PLOW;
      end
    return v[M-1:0];
  endfunction

  function automatic logic [M-1:0] xt(input logic [M-1:0] x);
    return {x[M-2:0], 1'b0} ^ (x[M-1] ? PLOW : '0);
  endfunction

  assign opnd  = inc ? ar : t;
  assign nacc  = xt(acc) ^ (b[M-1] ? opnd : '0);
  assign knext = inc ? k + 1'b1 : {k[EW-2:0], 1'b0};
  assign busy  = (st != S_IDLE);
  assign dout  = b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ar <= '0; b <= '0; t <= '0; acc <= '0;
      k <= '0; cnt <= '0; idx <= '0; mc <= '0; inc <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE:
          if (start) begin
            ar <= din; b <= din; t <= din;
            k <= EW'(1); cnt <= EW'(1); idx <= IW'(EW - 2); inc <= 1'b0;
            st <= S_SQ;
          end
        S_SQ: begin
          b <= sq(b);
          if (cnt == EW'(1)) begin
            acc <= '0;
            mc  <= CW'(M - 1);
            st  <= S_MUL;
          end else cnt <= cnt - 1'b1;
        end
        S_MUL: begin
          acc <= nacc;
          b   <= {b[M-2:0], 1'b0};
          mc  <= mc - 1'b1;
          if (mc == '0) begin
            b <= nacc;
            k <= knext;
            if (!inc && EXP[idx]) begin
              inc <= 1'b1; cnt <= EW'(1); st <= S_SQ;
            end else if (idx == '0) begin
              st <= S_FIN;
            end else begin
              idx <= idx - 1'b1; inc <= 1'b0; t <= nacc; cnt <= knext; st <= S_SQ;
            end
          end
        end
        S_FIN: begin
          b <= sq(b);
          done <= 1'b1;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gf2m_fermat_inv_chk.sv
module gf2m_fermat_inv_chk #(parameter int M = 163) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [M-1:0] dout,
  input logic         busy,
  input logic         done
);
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  a_r5_fall_done: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done);
  a_r6_start_busy: assert property (@(posedge clk) disable iff (!rst_n) (busy && start && !done) |=> (busy || done));
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !start) |=> $stable(dout));
endmodule

bind gf2m_fermat_inv gf2m_fermat_inv_chk #(.M(M)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .dout(dout), .busy(busy), .done(done)
);

// File: tb/gf2m_fermat_inv_bench.sv
module gf2m_fermat_inv_bench;
  localparam int M = 163;
  localparam int LAT = (M - 2) + 9 * M + 1;
  localparam int NV = 6;
  localparam logic [M-1:0] VEC [NV] = '{
    163'd1,
    163'd2,
    {1'b1, 162'd0},
    {163{1'b1}},
    {41{4'hA}} >> 1,
    163'h5_1234_5678_9ABC_DEF0_0FED_CBA9_8765_4321_0F0F_3C3C
  };

  logic clk = 0, rst_n = 0, start = 0;
  logic [M-1:0] din = '0;
  logic [M-1:0] dout;
  logic busy, done;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  gf2m_fermat_inv u_gf2m_fermat_inv (
    .clk(clk), .rst_n(rst_n), .start(start), .din(din),
    .dout(dout), .busy(busy), .done(done)
  );

  function automatic logic [M-1:0] refmul(input logic [M-1:0] x, input logic [M-1:0] y);
    logic [2*M-2:0] v;
    v = '0;
    for (int i = 0; i < M; i++) if (x[i]) v = v ^ ((2*M-1)'(y) << i);
    for (int i = 2*M-2; i >= M; i--)
      if (v[i]) begin
        v[i] = 1'b0;
        v[i-M+7] = ~v[i-M+7];
        v[i-M+6] = ~v[i-M+6];
        v[i-M+3] = ~v[i-M+3];
        v[i-M]   = ~v[i-M];
      end
    return v[M-1:0];
  endfunction

  task automatic check(input string req, input logic [M-1:0] act, input logic [M-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [M-1:0] a, input bit poke, output int lat, output logic [M-1:0] res);
    @(negedge clk); din = a; start = 1;
    @(negedge clk); start = 0;
    lat = 0;
    while (busy) begin
      lat++;
      if (poke && lat == 100) begin start = 1; din = ~a; end
      else start = 0;
      @(negedge clk);
    end
    start = 0;
    check("R5 done with busy fall", 163'(done), 163'd1);
    res = dout;
    @(negedge clk);
    check("R5 done single cycle", 163'(done), 163'd0);
    check("R7 result held", dout, res);
  endtask

  initial begin
    int lat;
    logic [M-1:0] res;
    repeat (3) @(negedge clk);
    check("R1 busy in reset", 163'(busy), 163'd0);
    check("R1 done in reset", 163'(done), 163'd0);
    check("R1 dout in reset", dout, '0);
    rst_n = 1;
    @(negedge clk);
    check("R1 dout after reset", dout, '0);
    for (int v = 0; v < NV; v++) begin
      run(VEC[v], 0, lat, res);
      check("R2 a*inv==1", refmul(VEC[v], res), 163'd1);
      check("R4 latency", 163'(lat), 163'(LAT));
    end
    run(163'd1, 0, lat, res);
    check("R3 inverse of one", res, 163'd1);
    run(163'd2, 0, lat, res);
    check("R3 inverse of z", res, (163'd1 << 162) | 163'h64);
    run(VEC[5], 1, lat, res);
    check("R6 start during busy ignored", refmul(VEC[5], res), 163'd1);
    check("R6 latency unchanged", 163'(lat), 163'(LAT));
    repeat (5) @(negedge clk);
    check("R7 idle hold", dout, res);
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule